// File: doc/BRIEF.md
# Interrupt Redirection Controller

The block collects a set of external interrupt lines and turns each activation into one interrupt-request message. Every line owns a 64-bit redirection entry holding the vector, delivery mode, destination mode, destination byte, trigger sense, polarity and mask. Software never addresses the entries directly. It writes an 8-bit internal offset into an index register, and the next access to the data window reads or writes the 32-bit register that the offset selects.

When an unmasked line activates, the line becomes pending. A round-robin picker moves one pending line into an output register, which presents the message on a valid/ready port until it is accepted. No acknowledge cycle runs toward the processor, so the message alone carries the vector. Level-sensitive lines set a remote-IRR flag when their message is accepted. The line stays silent until an end-of-interrupt arrives carrying the same vector.

Top module: `irq_redir_top`

## Requirements
- R1: After reset, every entry reads back with only the mask bit (bit 16) set, the index register reads 0, and no message is valid.
- R2: A write to bus offset 0x00 loads the 8-bit index, and reading offset 0x00 returns it. Reads and writes at bus offset 0x10 reach the internal register the index selects. Reads of any other bus offset return 0.
- R3: The low word of line n's entry is at internal offset 0x10+2n and the high word at 0x10+2n+1. The low word holds vector [7:0], delivery mode [10:8] (000 fixed, 001 lowest), destination mode [11] (1 = logical), polarity [13] (1 = active low), trigger [15] (1 = level) and mask [16]. The high word holds the destination in [31:24]. All other bits, and offsets outside the table and the version register, read 0.
- R4: Internal offset 0x01 is read-only and reads 0x00170020: the highest entry index (23) in [23:16] and the revision 0x20 in [7:0].
- R5: For an edge entry, each inactive-to-active transition of the line (active level set by polarity) yields exactly one message. A line held active yields no further message.
- R6: While the mask bit is set, the line produces no message. An edge that occurs while masked is not remembered.
- R7: A message carries the entry's vector, destination, delivery mode and destination mode. It stays valid with unchanged fields until ready is seen.
- R8: For a level entry, remote IRR (low-word bit 14, read-only) is set when its message is accepted and blocks further messages. An end-of-interrupt with the matching vector clears it, and a still-active line then sends again. A non-matching vector leaves it set.
- R9: Delivery status (low-word bit 12, read-only) is 1 from detection until the message is accepted.
- R10: Lines pending together are served in round-robin order, starting at the line after the last one loaded.
- R11: Writes to bits 12 and 14 of a low word, and to the version register, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe; data appears the next cycle |
| reg_addr_i | input | 8 | Bus offset (0x00 index, 0x10 data window) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| irq_i | input | 24 | Interrupt input lines |
| msg_valid_o | output | 1 | Message valid |
| msg_ready_i | input | 1 | Message accepted when high with valid |
| msg_vector_o | output | 8 | Message vector |
| msg_dest_o | output | 8 | Message destination |
| msg_dmode_o | output | 3 | Message delivery mode |
| msg_logical_o | output | 1 | Message destination mode (1 = logical) |
| eoi_valid_i | input | 1 | End-of-interrupt strobe |
| eoi_vector_i | input | 8 | Vector being retired |

## Verification
The assertions assume that interrupt lines are already synchronous to the clock and change only between edges. They also assume that the end-of-interrupt strobe is a single-cycle pulse. The stimulus drives every input at the falling edge and pulses strobes for exactly one cycle. Before changing a line's polarity or unmasking it, the stimulus first sets the line to a level that the new setting sees as inactive, so that reprogramming never creates an edge the test does not expect.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
  localparam logic [7:0] BUS_INDEX   = 8'h00;
  localparam logic [7:0] BUS_DATA    = 8'h10;
  localparam logic [7:0] REG_VERSION = 8'h01;
  localparam logic [7:0] TBL_BASE    = 8'h10;
  localparam logic [7:0] VERSION_ID  = 8'h20;

  typedef struct packed {
    logic [7:0] dest;
    logic       mask;
    logic       level;
    logic       act_low;
    logic       logical;
    logic [2:0] dmode;
    logic [7:0] vector;
  } rte_t;

  localparam rte_t RTE_RESET = '{mask: 1'b1, default: '0};
endpackage

// File: rtl/irq_redir_regfile.sv
module irq_redir_regfile
  import irq_redir_pkg::*;
#(
  parameter int unsigned N_LINES = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [7:0]          addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic [N_LINES-1:0]  busy_i,
  input  logic [N_LINES-1:0]  rirr_i,
  output rte_t                rte_o [N_LINES]
);
  localparam int TBL_END = int'(TBL_BASE) + 2 * int'(N_LINES);

  logic [7:0]  index_q;
  rte_t        tbl_q [N_LINES];
  logic [31:0] rdata_q, data_w, mux_w;
  logic [7:0]  offs_w;
  logic [6:0]  line_w;
  logic        hi_w, in_tbl_w;
  logic        unused_wbits;

  assign unused_wbits = ^{wdata_i[23:17], wdata_i[14], wdata_i[12]};
  assign in_tbl_w = (index_q >= TBL_BASE) && (int'(index_q) < TBL_END);
  assign offs_w   = index_q - TBL_BASE;
  assign line_w   = offs_w[7:1];
  assign hi_w     = offs_w[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      index_q <= '0;
      for (int n = 0; n < int'(N_LINES); n++) tbl_q[n] <= RTE_RESET;
    end else begin
      if (wr_i && addr_i == BUS_INDEX) index_q <= wdata_i[7:0];
      if (wr_i && addr_i == BUS_DATA && in_tbl_w) begin
        for (int n = 0; n < int'(N_LINES); n++) begin
          if (line_w == 7'(n)) begin
            if (hi_w) tbl_q[n].dest <= wdata_i[31:24];
            else begin
              tbl_q[n].mask    <= wdata_i[16];
              tbl_q[n].level   <= wdata_i[15];
              tbl_q[n].act_low <= wdata_i[13];
              tbl_q[n].logical <= wdata_i[11];
              tbl_q[n].dmode   <= wdata_i[10:8];
              tbl_q[n].vector  <= wdata_i[7:0];
            end
          end
        end
      end
    end
  end

  always_comb begin
    data_w = '0;
    if (index_q == REG_VERSION) data_w = {8'h00, 8'(N_LINES - 1), 8'h00, VERSION_ID};
    else if (in_tbl_w) begin
      for (int n = 0; n < int'(N_LINES); n++) begin
        if (line_w == 7'(n))
          data_w = hi_w ? {tbl_q[n].dest, 24'h0}
                        : {15'h0, tbl_q[n].mask, tbl_q[n].level, rirr_i[n],
                           tbl_q[n].act_low, busy_i[n], tbl_q[n].logical,
                           tbl_q[n].dmode, tbl_q[n].vector};
      end
    end
  end

  always_comb begin
    if (addr_i == BUS_INDEX)     mux_w = {24'h0, index_q};
    else if (addr_i == BUS_DATA) mux_w = data_w;
    else                         mux_w = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= mux_w;
  end

  assign rdata_o = rdata_q;
  for (genvar g = 0; g < int'(N_LINES); g++) begin : g_out
    assign rte_o[g] = tbl_q[g];
  end

  assert_index_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == BUS_INDEX) |=> (index_q == $past(wdata_i[7:0])));
  assert_version_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == BUS_DATA && index_q == REG_VERSION)
      |=> (rdata_o[23:16] == 8'(N_LINES - 1)));
endmodule

// File: rtl/irq_redir_line.sv
module irq_redir_line
  import irq_redir_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       irq_i,
  input  rte_t       rte_i,
  input  logic       load_i,
  input  logic       in_flight_i,
  input  logic       accept_lvl_i,
  input  logic       eoi_i,
  input  logic [7:0] eoi_vector_i,
  output logic       pend_o,
  output logic       rirr_o
);
  logic act_w, prev_q, pend_q, rirr_q, set_w, eoi_hit_w;

  assign act_w     = irq_i ^ rte_i.act_low;
  assign eoi_hit_w = eoi_i && (eoi_vector_i == rte_i.vector);
  // level lines stay blocked while in the output stage or awaiting EOI
  assign set_w = !rte_i.mask && act_w &&
                 (rte_i.level ? (!rirr_q && !in_flight_i && !load_i) : !prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      rirr_q <= 1'b0;
    end else begin
      prev_q <= act_w;
      pend_q <= set_w || (pend_q && !load_i);
      rirr_q <= accept_lvl_i || (rirr_q && !eoi_hit_w);
    end
  end

  assign pend_o = pend_q;
  assign rirr_o = rirr_q;

  assert_masked_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rte_i.mask && !pend_q) |=> !pend_q);
  assert_no_refire_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rte_i.level && !pend_q && prev_q && act_w) |=> !pend_q);
  assert_rirr_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rte_i.level && rirr_q && !pend_q) |=> !pend_q);
endmodule

// File: rtl/irq_redir_rr.sv
module irq_redir_rr #(
  parameter int unsigned N_LINES = 24,
  localparam int unsigned LW = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0] req_i,
  input  logic [LW-1:0]      ptr_i,
  output logic [LW-1:0]      sel_o,
  output logic               any_o
);
  int  j;
  logic found;

  always_comb begin
    sel_o = '0;
    found = 1'b0;
    j     = 0;
    for (int i = 0; i < int'(N_LINES); i++) begin
      j = int'(ptr_i) + i;
      if (j >= int'(N_LINES)) j = j - int'(N_LINES);
      if (!found && req_i[j]) begin
        found = 1'b1;
        sel_o = LW'(j);
      end
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/irq_redir_top.sv
module irq_redir_top
  import irq_redir_pkg::*;
#(
  parameter int unsigned N_LINES = 24,
  localparam int unsigned LW = $clog2(N_LINES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_wr_i,
  input  logic               reg_rd_i,
  input  logic [7:0]         reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  input  logic [N_LINES-1:0] irq_i,
  output logic               msg_valid_o,
  input  logic               msg_ready_i,
  output logic [7:0]         msg_vector_o,
  output logic [7:0]         msg_dest_o,
  output logic [2:0]         msg_dmode_o,
  output logic               msg_logical_o,
  input  logic               eoi_valid_i,
  input  logic [7:0]         eoi_vector_i
);
  rte_t               rte_w [N_LINES];
  logic [N_LINES-1:0] pend_w, rirr_w, busy_w, in_flight_w, load_w, acc_lvl_w;
  logic [LW-1:0]      sel_w, ptr_q, idx_q;
  logic               any_w, load, accept;
  logic               out_valid_q, out_level_q, out_logical_q;
  logic [7:0]         out_vector_q, out_dest_q;
  logic [2:0]         out_dmode_q;

  irq_redir_regfile #(.N_LINES(N_LINES)) u_regs (
    .clk_i, .rst_ni, .wr_i(reg_wr_i), .rd_i(reg_rd_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .busy_i(busy_w),
    .rirr_i(rirr_w), .rte_o(rte_w)
  );

  for (genvar g = 0; g < int'(N_LINES); g++) begin : g_line
    assign in_flight_w[g] = out_valid_q && (idx_q == LW'(g));
    assign load_w[g]      = load && (sel_w == LW'(g));
    assign acc_lvl_w[g]   = accept && out_level_q && (idx_q == LW'(g));
    assign busy_w[g]      = pend_w[g] || in_flight_w[g];
    irq_redir_line u_line (
      .clk_i, .rst_ni, .irq_i(irq_i[g]), .rte_i(rte_w[g]), .load_i(load_w[g]),
      .in_flight_i(in_flight_w[g]), .accept_lvl_i(acc_lvl_w[g]),
      .eoi_i(eoi_valid_i), .eoi_vector_i, .pend_o(pend_w[g]), .rirr_o(rirr_w[g])
    );
  end

  irq_redir_rr #(.N_LINES(N_LINES)) u_rr (
    .req_i(pend_w), .ptr_i(ptr_q), .sel_o(sel_w), .any_o(any_w)
  );

  assign accept = out_valid_q && msg_ready_i;
  assign load   = any_w && (!out_valid_q || msg_ready_i);

  // output stage latches the entry so the payload is stable under backpressure
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q   <= 1'b0;
      idx_q         <= '0;
      ptr_q         <= '0;
      out_level_q   <= 1'b0;
      out_logical_q <= 1'b0;
      out_vector_q  <= '0;
      out_dest_q    <= '0;
      out_dmode_q   <= '0;
    end else if (load) begin
      out_valid_q   <= 1'b1;
      idx_q         <= sel_w;
      ptr_q         <= (sel_w == LW'(N_LINES - 1)) ? '0 : sel_w + 1'b1;
      out_level_q   <= rte_w[sel_w].level;
      out_logical_q <= rte_w[sel_w].logical;
      out_vector_q  <= rte_w[sel_w].vector;
      out_dest_q    <= rte_w[sel_w].dest;
      out_dmode_q   <= rte_w[sel_w].dmode;
    end else if (accept) begin
      out_valid_q   <= 1'b0;
    end
  end

  assign msg_valid_o   = out_valid_q;
  assign msg_vector_o  = out_vector_q;
  assign msg_dest_o    = out_dest_q;
  assign msg_dmode_o   = out_dmode_q;
  assign msg_logical_o = out_logical_q;

  assert_msg_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && !msg_ready_i) |=> (msg_valid_o && $stable(msg_vector_o) &&
      $stable(msg_dest_o) && $stable(msg_dmode_o) && $stable(msg_logical_o)));
  assert_status_covers_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && !msg_ready_i) |=> (busy_w[idx_q] && $onehot0(in_flight_w)));
endmodule

// File: tb/irq_redir_top_tb_top.sv
`timescale 1ns/1ps
module irq_redir_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [23:0] irq = '0;
  logic        mvalid, mready = 1'b0, mlogical;
  logic [7:0]  mvector, mdest;
  logic [2:0]  mdmode;
  logic        eoi_v = 1'b0;
  logic [7:0]  eoi_vec = '0;
  int          n_vec = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  irq_redir_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_i(irq), .msg_valid_o(mvalid),
    .msg_ready_i(mready), .msg_vector_o(mvector), .msg_dest_o(mdest),
    .msg_dmode_o(mdmode), .msg_logical_o(mlogical), .eoi_valid_i(eoi_v),
    .eoi_vector_i(eoi_vec)
  );

  typedef struct packed { logic [7:0] idx; logic [31:0] wd; logic [31:0] ex; } vec_t;
  localparam vec_t VECS [8] = '{
    '{8'h10, 32'hFFFF_FFFF, 32'h0001_AFFF},  // R3 R11 line0 low, RO bits dropped
    '{8'h11, 32'hFFFF_FFFF, 32'hFF00_0000},  // R3 line0 high
    '{8'h3E, 32'h0001_5A5A, 32'h0001_0A5A},  // R3 R11 line23 low
    '{8'h3F, 32'h1200_0000, 32'h1200_0000},  // R3 line23 high
    '{8'h01, 32'h0000_DEAD, 32'h0017_0020},  // R4 R11 version read-only
    '{8'h40, 32'h0000_0001, 32'h0000_0000},  // R3 past table end
    '{8'h00, 32'h0000_0001, 32'h0000_0000},  // R3 unmapped internal offset
    '{8'h20, 32'h0000_0031, 32'h0000_0031}   // R3 line8 low
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic reg_wr(input logic [7:0] idx, input logic [31:0] d);
    bus_wr(8'h00, {24'h0, idx}); bus_wr(8'h10, d);
  endtask

  task automatic reg_rd(input logic [7:0] idx, output logic [31:0] d);
    bus_wr(8'h00, {24'h0, idx}); bus_rd(8'h10, d);
  endtask

  task automatic set_entry(input int n, input logic [31:0] lo, input logic [7:0] dst);
    reg_wr(8'(8'h11 + 2 * n), {dst, 24'h0});
    reg_wr(8'(8'h10 + 2 * n), lo);
  endtask

  task automatic expect_msg(input string req, input logic [7:0] v, input logic [7:0] d,
                            input logic [2:0] m, input logic l);
    logic got = 1'b0;
    for (int i = 0; i < 20 && !got; i++) begin
      @(negedge clk);
      got = mvalid;
    end
    chk({req, " valid"}, {31'h0, got}, 32'h1);
    chk({req, " vector"}, {24'h0, mvector}, {24'h0, v});
    chk({req, " dest"}, {24'h0, mdest}, {24'h0, d});
    chk({req, " mode"}, {28'h0, mlogical, mdmode}, {28'h0, l, m});
  endtask

  task automatic expect_quiet(input string req, input int cyc);
    logic seen = 1'b0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      seen = seen | mvalid;
    end
    chk(req, {31'h0, seen}, 32'h0);
  endtask

  task automatic accept();
    @(negedge clk) mready = 1'b1;
    @(negedge clk) mready = 1'b0;
  endtask

  task automatic eoi(input logic [7:0] v);
    @(negedge clk); eoi_v = 1'b1; eoi_vec = v;
    @(negedge clk); eoi_v = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    logic [31:0] d;
    do_reset();
    // R1 reset state
    chk("R1 valid", {31'h0, mvalid}, 32'h0);
    bus_rd(8'h00, d); chk("R1 index", d, 32'h0);
    reg_rd(8'h1A, d); chk("R1 entry5 low", d, 32'h0001_0000);
    reg_rd(8'h1B, d); chk("R1 entry5 high", d, 32'h0);

    // R2 index readback and unmapped bus offset
    bus_wr(8'h00, 32'h0000_0037);
    bus_rd(8'h00, d); chk("R2 index readback", d, 32'h37);
    bus_rd(8'h08, d); chk("R2 other bus offset", d, 32'h0);

    foreach (VECS[k]) begin
      reg_wr(VECS[k].idx, VECS[k].wd);
      reg_rd(VECS[k].idx, d);
      chk($sformatf("R3 vector %0d", k), d, VECS[k].ex);
    end

    // R5 R7 R9 edge, active high
    set_entry(4, 32'h0000_0941, 8'hFF);
    irq[4] = 1'b1;
    expect_msg("R7 edge msg", 8'h41, 8'hFF, 3'd1, 1'b1);
    repeat (3) @(negedge clk);
    chk("R7 held", {31'h0, mvalid}, 32'h1);
    chk("R7 held vector", {24'h0, mvector}, 32'h41);
    reg_rd(8'h18, d); chk("R9 status pending", d, 32'h0000_1941);
    accept();
    expect_quiet("R5 held line no refire", 10);
    reg_rd(8'h18, d); chk("R9 status cleared", d, 32'h0000_0941);

    // R5 active-low polarity
    irq[6] = 1'b1;
    set_entry(6, 32'h0000_2066, 8'h03);
    expect_quiet("R5 inactive low line", 10);
    irq[6] = 1'b0;
    expect_msg("R5 active low", 8'h66, 8'h03, 3'd0, 1'b0);
    accept();

    // R6 mask
    set_entry(9, 32'h0001_0077, 8'h00);
    irq[9] = 1'b1;
    expect_quiet("R6 masked", 10);
    reg_rd(8'h22, d); chk("R6 masked status", d, 32'h0001_0077);
    irq[9] = 1'b0;
    reg_wr(8'h22, 32'h0000_0077);
    expect_quiet("R6 edge while masked lost", 10);
    irq[9] = 1'b1;
    expect_msg("R6 unmasked edge", 8'h77, 8'h00, 3'd0, 1'b0);
    accept();

    // R8 level with remote IRR
    set_entry(10, 32'h0000_8088, 8'h01);
    irq[10] = 1'b1;
    expect_msg("R8 level msg", 8'h88, 8'h01, 3'd0, 1'b0);
    accept();
    reg_rd(8'h24, d); chk("R8 rirr set", d, 32'h0000_C088);
    expect_quiet("R8 blocked", 10);
    eoi(8'h89);
    expect_quiet("R8 wrong eoi", 8);
    reg_rd(8'h24, d); chk("R8 rirr kept", d, 32'h0000_C088);
    eoi(8'h88);
    expect_msg("R8 refire after eoi", 8'h88, 8'h01, 3'd0, 1'b0);
    accept();
    irq[10] = 1'b0;
    eoi(8'h88);
    expect_quiet("R8 inactive after eoi", 10);
    reg_rd(8'h24, d); chk("R8 rirr cleared", d, 32'h0000_8088);

    // R10 round robin
    irq = '0;
    do_reset();
    chk("R1 second reset", {31'h0, mvalid}, 32'h0);
    set_entry(3, 32'h0000_0033, 8'h00);
    set_entry(5, 32'h0000_0055, 8'h00);
    set_entry(7, 32'h0000_0077, 8'h00);
    @(negedge clk) irq = 24'h0000A8;
    expect_msg("R10 first", 8'h33, 8'h00, 3'd0, 1'b0);
    accept();
    expect_msg("R10 second", 8'h55, 8'h00, 3'd0, 1'b0);
    @(negedge clk) irq[3] = 1'b0;
    @(negedge clk) irq[3] = 1'b1;
    repeat (3) @(negedge clk);
    accept();
    expect_msg("R10 rotation skips lower line", 8'h77, 8'h00, 3'd0, 1'b0);
    accept();
    expect_msg("R10 wraps", 8'h33, 8'h00, 3'd0, 1'b0);
    accept();
    expect_quiet("R10 drained", 10);

    summary();
  end
endmodule